// File: doc/BRIEF.md
# Strip History Row Buffer

This block collects sparse hits from four readout-chip input queues and files each one into a small history memory. Every row of that memory has one slot for each of the 121 strips of the sensor. A slot is either empty or holds a 64-bit payload. Each hit carries a strip index, an 8-bit readout-cycle tag and its payload. A round-robin arbiter takes one hit per cycle from the heads of the four queues. The hit goes into the slot of its strip, in the row that belongs to its readout cycle.

The memory keeps four rows. The row of a cycle tag is its two low bits, so row use wraps around over the history. A hit whose tag is ahead of the current cycle first moves the current cycle forward. Each step clears one complete row to empty in a single cycle, through a second and wider write port. A hit for one of the three previous cycles still lands in the row that was kept for that cycle. Any selected row can be read out whole at any time, for the cluster logic that follows.

Top module: `strip_history_buffer`

## Requirements
- R1: Each cycle, at most one source is popped. A source is popped only while its valid bit is high. Sources that all stay valid are served in rotating order, and each is served once before any is served again.
- R2: A hit whose tag equals the current tag and whose strip is below 121 is popped. It sets the valid bit of slot `strip`, in row `tag[1:0]`, and stores its payload there.
- R3: A later hit to an occupied slot replaces that slot's payload.
- R4: Take `ahead = (tag - cur_tag) mod 256`. A hit with `ahead` in 1..127 is held and not popped. On each held cycle, `cur_tag` increases by one and row `(new cur_tag)[1:0]` is cleared completely, so the hit waits exactly `ahead` cycles. It is then handled as in R2.
- R5: A hit whose tag is 1 to 3 behind `cur_tag` (mod 256) is written into row `tag[1:0]`. This leaves the current row untouched.
- R6: A hit whose tag is 4 to 128 behind `cur_tag` is popped and discarded, and no row changes.
- R7: A hit with a strip index of 121 or more is popped and discarded. It does not move `cur_tag` and changes no row.
- R8: Row `rd_row` appears on the read outputs one clock after it is applied. Slot i appears in `rd_valid[i]` and `rd_data[i*64 +: 64]`. A row keeps its contents until it is cleared by an advance.
- R9: After reset, `cur_tag` is 0, every slot of every row is empty, and no source is popped while all valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 4 | Head-of-queue valid, one per source |
| src_strip | input | 28 | Strip index per source, 7 bits each, source s at [7s +: 7] |
| src_tag | input | 32 | Readout-cycle tag per source, 8 bits each |
| src_data | input | 256 | Hit payload per source, 64 bits each |
| src_pop | output | 4 | Consume the head of that source this cycle |
| cur_tag | output | 8 | Readout-cycle tag of the current row |
| rd_row | input | 2 | Row selected for readout |
| rd_valid | output | 121 | Slot occupancy of the selected row, registered |
| rd_data | output | 7744 | Slot payloads of the selected row, registered |

## Verification
The bench goes after the edges of the tag window, where most mistakes in this design would show. It sends a jump of three cycles, which must clear exactly three rows and stall for three cycles. A design that cleared only the target row would leave stale strips visible in the skipped rows. Tags one and four behind the current cycle must be written and dropped respectively. An off-by-one in the history test would either corrupt a row that the cluster logic trusts or lose good late hits. Out-of-range strip indices must be consumed without any side effect, and four busy sources must come out in a strictly rotating order. A run of random hits across the whole window then compares every row against an independent model.

// File: rtl/strip_hist_pkg.sv
package strip_hist_pkg;

    localparam int HS_SRC    = 4;
    localparam int HS_SLOTS  = 121;
    localparam int HS_DATA_W = 64;
    localparam int HS_TAG_W  = 8;
    localparam int HS_ROWS   = 4;

    localparam int SLOT_W = $clog2(HS_SLOTS);
    localparam int ROW_W  = $clog2(HS_ROWS);
    localparam logic [HS_TAG_W-1:0] TAG_HALF = HS_TAG_W'(1) << (HS_TAG_W - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]    strip;
        logic [HS_TAG_W-1:0]  tag;
        logic [HS_DATA_W-1:0] data;
    } hit_t;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_WRITE   = 2'd1,
        ACT_ADVANCE = 2'd2,
        ACT_DROP    = 2'd3
    } act_e;

    // Decide what to do with the granted head against the current cycle tag.
    function automatic act_e classify(input logic vld, input hit_t h,
                                      input logic [HS_TAG_W-1:0] cur);
        logic [HS_TAG_W-1:0] ahead;
        logic [HS_TAG_W-1:0] behind;
        ahead  = h.tag - cur;
        behind = cur - h.tag;
        if (!vld)                               return ACT_IDLE;
        if (h.strip >= SLOT_W'(HS_SLOTS))       return ACT_DROP;
        if (ahead != '0 && ahead < TAG_HALF)    return ACT_ADVANCE;
        if (behind < HS_TAG_W'(HS_ROWS))        return ACT_WRITE;
        return ACT_DROP;
    endfunction

endpackage

// File: rtl/hs_rr_arbiter.sv
module hs_rr_arbiter #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 accept,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        any = 1'b0;
        idx = ptr_q;
        for (int k = 0; k < N; k++) begin
            logic [IDX_W-1:0] cand;
            cand = ptr_q + IDX_W'(k);
            if (!any && req[cand]) begin
                any = 1'b1;
                idx = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (accept)
            ptr_q <= idx + IDX_W'(1);
    end

    // R1
    grant_is_requester_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> req[idx]);

    // R1
    accept_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> any);

endmodule

// File: rtl/hs_row_store.sv
module hs_row_store #(
    parameter int ROWS   = 4,
    parameter int SLOTS  = 121,
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(ROWS)-1:0]   wr_row,
    input  logic [$clog2(SLOTS)-1:0]  wr_slot,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      clr_en,
    input  logic [$clog2(ROWS)-1:0]   clr_row,
    input  logic [$clog2(ROWS)-1:0]   rd_row,
    output logic [SLOTS-1:0]          rd_valid,
    output logic [SLOTS*DATA_W-1:0]   rd_data
);
    logic [ROWS-1:0][SLOTS-1:0]             occ_q;
    logic [ROWS-1:0][SLOTS-1:0][DATA_W-1:0] mem_q;

    // Occupancy: narrow port sets one bit, wide port empties a whole row.
    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            if (clr_en)
                occ_q[clr_row] <= '0;
            if (wr_en)
                occ_q[wr_row][wr_slot] <= 1'b1;
        end
    end

    // Payload array carries no reset; occupancy qualifies it.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_row][wr_slot] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= occ_q[rd_row];
            rd_data  <= mem_q[rd_row];
        end
    end

    // R4
    clear_empties_row_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> occ_q[$past(clr_row)] == '0);

    // R2
    write_marks_slot_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> occ_q[$past(wr_row)][$past(wr_slot)]);

    // R4
    ports_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && clr_en));

    // R7
    slot_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_slot < ($clog2(SLOTS))'(SLOTS));

endmodule

// File: rtl/strip_history_buffer.sv
module strip_history_buffer
    import strip_hist_pkg::*;
#(
    parameter int NUM_SRC = HS_SRC
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            src_valid,
    input  logic [NUM_SRC*SLOT_W-1:0]     src_strip,
    input  logic [NUM_SRC*HS_TAG_W-1:0]   src_tag,
    input  logic [NUM_SRC*HS_DATA_W-1:0]  src_data,
    output logic [NUM_SRC-1:0]            src_pop,
    output logic [HS_TAG_W-1:0]           cur_tag,
    input  logic [ROW_W-1:0]              rd_row,
    output logic [HS_SLOTS-1:0]           rd_valid,
    output logic [HS_SLOTS*HS_DATA_W-1:0] rd_data
);
    localparam int SRC_W = $clog2(NUM_SRC);

    hit_t                heads [NUM_SRC];
    hit_t                sel;
    logic                gnt_any;
    logic [SRC_W-1:0]    gnt_idx;
    act_e                act;
    logic [HS_TAG_W-1:0] tag_q;
    logic [HS_TAG_W-1:0] tag_next;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign heads[g] = '{strip: src_strip[g*SLOT_W +: SLOT_W],
                            tag:   src_tag[g*HS_TAG_W +: HS_TAG_W],
                            data:  src_data[g*HS_DATA_W +: HS_DATA_W]};
    end

    hs_rr_arbiter #(.N(NUM_SRC)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (src_valid),
        .accept (|src_pop),
        .any    (gnt_any),
        .idx    (gnt_idx)
    );

    assign sel      = heads[gnt_idx];
    assign act      = classify(gnt_any, sel, tag_q);
    assign tag_next = tag_q + HS_TAG_W'(1);
    assign cur_tag  = tag_q;

    always_comb begin
        src_pop = '0;
        if (act == ACT_WRITE || act == ACT_DROP)
            src_pop[gnt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tag_q <= '0;
        else if (act == ACT_ADVANCE)
            tag_q <= tag_next;
    end

    hs_row_store #(.ROWS(HS_ROWS), .SLOTS(HS_SLOTS), .DATA_W(HS_DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (act == ACT_WRITE),
        .wr_row   (sel.tag[ROW_W-1:0]),
        .wr_slot  (sel.strip),
        .wr_data  (sel.data),
        .clr_en   (act == ACT_ADVANCE),
        .clr_row  (tag_next[ROW_W-1:0]),
        .rd_row   (rd_row),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R1
    single_pop_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_pop));

    // R1
    pop_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (src_pop & ~src_valid) == '0);

    // R4
    advance_steps_one_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ADVANCE) |=> cur_tag == $past(cur_tag) + HS_TAG_W'(1));

    // R4
    advance_holds_head_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ADVANCE) |-> src_pop == '0);

    // R7
    tag_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (act != ACT_ADVANCE) |=> $stable(cur_tag));

endmodule

// File: tb/strip_history_buffer_tb.sv
`timescale 1ns/1ps
module strip_history_buffer_tb;
    import strip_hist_pkg::*;

    localparam int NS = HS_SRC;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic [NS-1:0]                 src_valid = '0;
    logic [NS*SLOT_W-1:0]          src_strip = '0;
    logic [NS*HS_TAG_W-1:0]        src_tag = '0;
    logic [NS*HS_DATA_W-1:0]       src_data = '0;
    logic [NS-1:0]                 src_pop;
    logic [HS_TAG_W-1:0]           cur_tag;
    logic [ROW_W-1:0]              rd_row = '0;
    logic [HS_SLOTS-1:0]           rd_valid;
    logic [HS_SLOTS*HS_DATA_W-1:0] rd_data;

    strip_history_buffer u_dut (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_strip(src_strip),
        .src_tag(src_tag), .src_data(src_data), .src_pop(src_pop),
        .cur_tag(cur_tag), .rd_row(rd_row), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    hit_t srcq [NS][$];
    int   pop_log [$];
    int   checks = 0;
    int   errors = 0;
    int   stalls = 0;
    int   pop_viol = 0;
    bit   done = 0;

    bit                   exp_v [HS_ROWS][HS_SLOTS];
    logic [HS_DATA_W-1:0] exp_d [HS_ROWS][HS_SLOTS];
    logic [HS_TAG_W-1:0]  exp_tag = '0;

    // Independent model of the requirements, applied in pop order.
    task automatic model_apply(hit_t h);
        logic [HS_TAG_W-1:0] ahead;
        logic [HS_TAG_W-1:0] behind;
        if (int'(h.strip) >= HS_SLOTS) return;                 // R7
        ahead = h.tag - exp_tag;
        if (ahead != 0 && ahead < 128) begin                    // R4
            while (exp_tag != h.tag) begin
                exp_tag = exp_tag + 1;
                for (int i = 0; i < HS_SLOTS; i++) exp_v[exp_tag % HS_ROWS][i] = 0;
            end
        end
        behind = exp_tag - h.tag;
        if (behind < HS_ROWS) begin                             // R2 R3 R5
            exp_v[h.tag % HS_ROWS][h.strip] = 1;
            exp_d[h.tag % HS_ROWS][h.strip] = h.data;
        end                                                     // else R6 drop
    endtask

    // Driver side: source queues presented at the falling edge, pops observed before the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                if (srcq[s].size() > 0) begin
                    src_valid[s] = 1'b1;
                    src_strip[s*SLOT_W +: SLOT_W]       = srcq[s][0].strip;
                    src_tag[s*HS_TAG_W +: HS_TAG_W]     = srcq[s][0].tag;
                    src_data[s*HS_DATA_W +: HS_DATA_W]  = srcq[s][0].data;
                end else begin
                    src_valid[s] = 1'b0;
                end
            end
            #1;
            if (!rst) begin
                if ($countones(src_pop) > 1 || (src_pop & ~src_valid) != '0) pop_viol++;
                if (src_valid != '0 && src_pop == '0) stalls++;
                for (int s = 0; s < NS; s++) begin
                    if (src_pop[s] && srcq[s].size() > 0) begin
                        hit_t h;
                        h = srcq[s].pop_front();
                        model_apply(h);
                        pop_log.push_back(s);
                    end
                end
            end
        end
    end

    task automatic send(int s, int strip, int tag);
        hit_t h;
        h.strip = SLOT_W'(strip);
        h.tag   = HS_TAG_W'(tag);
        h.data  = {$urandom(), $urandom()};
        srcq[s].push_back(h);
    endtask

    task automatic wait_idle();
        while (srcq[0].size() + srcq[1].size() + srcq[2].size() + srcq[3].size() > 0)
            @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_row(string req, int r);
        int bad_slot;
        @(negedge clk);
        rd_row = ROW_W'(r);
        @(posedge clk);
        @(negedge clk);
        bad_slot = -1;
        for (int i = 0; i < HS_SLOTS; i++) begin
            if (bad_slot < 0 && (rd_valid[i] !== exp_v[r][i] ||
                (exp_v[r][i] && rd_data[i*HS_DATA_W +: HS_DATA_W] !== exp_d[r][i])))
                bad_slot = i;
        end
        checks++;
        if (bad_slot >= 0) begin
            errors++;
            $display("FAIL %s: row %0d slot %0d actual v=%0b d=%h expected v=%0b d=%h",
                     req, r, bad_slot, rd_valid[bad_slot],
                     rd_data[bad_slot*HS_DATA_W +: HS_DATA_W],
                     exp_v[r][bad_slot], exp_d[r][bad_slot]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=completion");
        finish_run();
    end

    initial begin
        for (int r = 0; r < HS_ROWS; r++)
            for (int i = 0; i < HS_SLOTS; i++) begin
                exp_v[r][i] = 0;
                exp_d[r][i] = '0;
            end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R9 reset state
        check_val("R9 cur_tag", int'(cur_tag), 0);
        check_val("R9 no pop idle", int'(src_pop), 0);
        for (int r = 0; r < HS_ROWS; r++) check_row("R9 empty row", r);

        // R2 basic writes including both ends of the strip range
        send(0, 0, 0); send(1, 5, 0); send(2, 120, 0);
        wait_idle();
        check_row("R2 write row0", 0);

        // R3 overwrite
        send(3, 5, 0);
        wait_idle();
        check_row("R3 overwrite", 0);

        // R7 out-of-range strips, even with a newer tag
        send(0, 121, 0); send(1, 127, 2);
        wait_idle();
        check_val("R7 tag unmoved", int'(cur_tag), 0);
        check_row("R7 row0 unchanged", 0);
        check_row("R7 row2 unchanged", 2);

        // R4 one-step advance, R8 previous row kept
        stalls = 0;
        send(0, 3, 1);
        wait_idle();
        check_val("R4 one stall", stalls, 1);
        check_val("R4 tag 1", int'(cur_tag), 1);
        check_row("R4 row1", 1);
        check_row("R8 row0 kept", 0);

        // R5 late hit for the previous cycle
        send(2, 7, 0);
        wait_idle();
        check_row("R5 late write row0", 0);
        check_row("R5 row1 untouched", 1);

        // R4 three-step jump clears rows 2, 3, 0
        stalls = 0;
        send(1, 9, 4);
        wait_idle();
        check_val("R4 three stalls", stalls, 3);
        check_val("R4 tag 4", int'(cur_tag), 4);
        for (int r = 0; r < HS_ROWS; r++) check_row("R4 after jump", r);

        // R6 four behind dropped; R5 three behind kept
        send(0, 11, 0); send(0, 12, 1);
        wait_idle();
        check_row("R6 stale dropped row0", 0);
        check_row("R5 three behind row1", 1);

        // R1 rotating service among four busy sources
        @(posedge clk);
        pop_log.delete();
        for (int k = 0; k < 2; k++)
            for (int s = 0; s < NS; s++) send(s, 20 + k * NS + s, 4);
        wait_idle();
        begin
            bit [NS-1:0] seen;
            bit ok;
            seen = '0;
            ok = (pop_log.size() == 2 * NS);
            if (ok) begin
                for (int i = 0; i < NS; i++) seen[pop_log[i]] = 1'b1;
                for (int i = 0; i < NS; i++) if (pop_log[i + NS] != pop_log[i]) ok = 0;
            end
            check_val("R1 rotation order", int'(ok && seen == '1), 1);
        end
        check_row("R1 data row0", 0);

        // Random traffic across the tag window, all sources together
        for (int n = 0; n < 240; n++) begin
            int s;
            int t;
            s = $urandom_range(NS - 1);
            t = int'(exp_tag) + 8 * (n / 40) + $urandom_range(7) - 5;
            send(s, $urandom_range(126), t & 255);
            if (n % 20 == 19) wait_idle();
        end
        wait_idle();
        check_val("R4 random final tag", int'(cur_tag), int'(exp_tag));
        for (int r = 0; r < HS_ROWS; r++) check_row("R2 R5 R6 random row", r);

        check_val("R1 pop legality", pop_viol, 0);
        finish_run();
    end

endmodule